// File: doc/BRIEF.md
# Tagged Reconfigurable Functional Unit

This block sits beside a processor's register file and executes custom instructions on a small programmable array that holds no state. Each custom instruction arrives with an 11-bit identifier and two register operands. The unit compares the identifier with the tag of the configuration currently loaded. When they match, the result is produced combinationally in the same cycle. When they do not match, the unit flags a miss and holds the pipeline with a stall.

Once the processor sees a miss, it pushes a new tag and operation selector through the configuration port. Loading that configuration takes a fixed number of cycles, and the stall stays high for all of them. The new tag takes effect only when the load finishes. If the stalled instruction is still being presented at that point, it then matches and completes. The array content is represented here by a choice of eight small word operations. The selector for that choice is kept next to the tag.

Top module: `rfu_tagged_unit`

## Requirements
- R1: After reset no configuration tag is valid, so the first issued instruction, whatever its identifier, gives miss_o=1, stall_o=1, valid_o=0.
- R2: When issue_i is high, no load is in progress and id_i equals the loaded tag in all 11 bits, the same cycle shows valid_o=1, miss_o=0, stall_o=0, and result_o holds the operation's value for opa_i and opb_i.
- R3: When issue_i is high, no load is in progress and id_i differs from the loaded tag in any bit (including bit 10), or no tag is valid, the same cycle shows miss_o=1, stall_o=1, valid_o=0 and result_o=0.
- R4: A cfg_wr_i pulse accepted at a clock edge holds stall_o high for exactly LOAD_CYCLES cycles after that edge, with valid_o=0 and miss_o=0 for that whole time.
- R5: The loaded tag changes only when a load finishes. After the load, the new identifier matches and the previous identifier misses. An instruction held stalled through the load completes once the load ends.
- R6: Operation selector encodings: 0 AND, 1 OR, 2 XOR, 3 ADD modulo 2^DATA_W, 4 SUB (opa-opb) modulo 2^DATA_W, 5 shift opa left by opb[log2(DATA_W)-1:0], 6 logical shift opa right by the same amount, 7 count of one bits in opa.
- R7: With issue_i low and no load in progress, valid_o, miss_o and stall_o are all 0 and result_o is 0.
- R8: A cfg_wr_i pulse that arrives while a load is in progress is ignored. The earlier load finishes on time with its own tag, and the ignored tag misses afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Custom instruction presented this cycle |
| id_i | input | ID_W | Identifier of the presented instruction |
| opa_i | input | DATA_W | First register operand |
| opb_i | input | DATA_W | Second register operand |
| cfg_wr_i | input | 1 | Start loading a configuration |
| cfg_tag_i | input | ID_W | Tag of the configuration being loaded |
| cfg_op_i | input | 3 | Operation selector stored with the tag |
| result_o | output | DATA_W | Result, nonzero only on a hit |
| valid_o | output | 1 | Instruction completes this cycle |
| miss_o | output | 1 | Identifier does not match the loaded configuration |
| stall_o | output | 1 | Hold the processor pipeline |

## Verification
The bench targets three kinds of error. The first is a design that does not mask the shift amount, which would produce zero for a shift by 36. The second is a design that compares only part of the identifier, which would let an identifier differing only in bit 10 hit. The third is a design that commits the new tag at the start of a load instead of at its end, which would let the stalled instruction complete early while the stall is still meant to be high. It also checks that the stall lasts exactly LOAD_CYCLES cycles, since an off-by-one in the load counter shortens or lengthens the stall. A second cfg_wr_i during a load is checked as well: a design that accepted it would restart the load or swap in the wrong tag.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
    localparam int RFU_ID_W = 11;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_ADD = 3'd3,
        OP_SUB = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6,
        OP_POP = 3'd7
    } rfu_op_e;
endpackage

// File: rtl/rfu_op_array.sv
module rfu_op_array
    import rfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  rfu_op_e             op_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [DATA_W-1:0]   y_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] pop_cnt;

    assign sh_amt = b_i[SH_W-1:0];

    always_comb begin
        pop_cnt = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pop_cnt = pop_cnt + DATA_W'(a_i[i]);
        end
    end

    always_comb begin
        unique case (op_i)
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_SHL:  y_o = a_i << sh_amt;
            OP_SHR:  y_o = a_i >> sh_amt;
            default: y_o = pop_cnt;
        endcase
    end
endmodule

// File: rtl/rfu_cfg_loader.sv
module rfu_cfg_loader
    import rfu_pkg::*;
#(
    parameter int ID_W        = RFU_ID_W,
    parameter int LOAD_CYCLES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr_i,
    input  logic [ID_W-1:0] cfg_tag_i,
    input  rfu_op_e         cfg_op_i,
    output logic            busy_o,
    output logic            tag_valid_o,
    output logic [ID_W-1:0] tag_o,
    output rfu_op_e         op_o
);
    localparam int CNT_W = $clog2(LOAD_CYCLES + 1);

    typedef struct packed {
        logic            busy;
        logic [CNT_W-1:0] cnt;
        logic            tag_valid;
        logic [ID_W-1:0] tag;
        rfu_op_e         op;
        logic [ID_W-1:0] pend_tag;
        rfu_op_e         pend_op;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy      = 1'b0;
                st_d.tag_valid = 1'b1;
                st_d.tag       = st_q.pend_tag;
                st_d.op        = st_q.pend_op;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (cfg_wr_i) begin
            st_d.busy     = 1'b1;
            st_d.cnt      = CNT_W'(LOAD_CYCLES - 1);
            st_d.pend_tag = cfg_tag_i;
            st_d.pend_op  = cfg_op_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0, tag_valid: 1'b0, tag: '0,
                      op: OP_AND, pend_tag: '0, pend_op: OP_AND};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign tag_valid_o = st_q.tag_valid;
    assign tag_o       = st_q.tag;
    assign op_o        = st_q.op;

    // R4: an accepted strobe starts the load on the next edge
    a_r4_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !st_q.busy) |=> st_q.busy);

    // R5: the live tag moves only out of a load
    a_r5_tag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |=> $stable(st_q.tag));

    // R8: the pending tag is frozen while a load runs
    a_r8_pend_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.pend_tag));
endmodule

// File: rtl/rfu_tagged_unit.sv
module rfu_tagged_unit
    import rfu_pkg::*;
#(
    parameter int ID_W        = RFU_ID_W,
    parameter int DATA_W      = 32,
    parameter int LOAD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              cfg_wr_i,
    input  logic [ID_W-1:0]   cfg_tag_i,
    input  logic [2:0]        cfg_op_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              miss_o,
    output logic              stall_o
);
    logic              busy;
    logic              tag_valid;
    logic [ID_W-1:0]   tag;
    rfu_op_e           cur_op;
    logic [DATA_W-1:0] array_y;
    logic              hit;

    rfu_cfg_loader #(
        .ID_W        (ID_W),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) i_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_tag_i   (cfg_tag_i),
        .cfg_op_i    (rfu_op_e'(cfg_op_i)),
        .busy_o      (busy),
        .tag_valid_o (tag_valid),
        .tag_o       (tag),
        .op_o        (cur_op)
    );

    rfu_op_array #(
        .DATA_W (DATA_W)
    ) i_array (
        .op_i (cur_op),
        .a_i  (opa_i),
        .b_i  (opb_i),
        .y_o  (array_y)
    );

    always_comb begin
        hit      = issue_i && !busy && tag_valid && (id_i == tag);
        valid_o  = hit;
        miss_o   = issue_i && !busy && !hit;
        stall_o  = busy || miss_o;
        result_o = hit ? array_y : '0;
    end

    // R3: a miss always holds the pipeline and never completes
    a_r3_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (stall_o && !valid_o && result_o == '0));

    // R2: a completion needs an instruction and never stalls
    a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (issue_i && !stall_o && !miss_o));

    // R4: nothing completes or misses while a load runs
    a_r4_quiet_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (stall_o && !valid_o && !miss_o));

    // R7: idle unit drives nothing
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i && !busy) |-> (!stall_o && !valid_o && result_o == '0));
endmodule

// File: tb/test_rfu_tagged_unit.sv
module test_rfu_tagged_unit;
    localparam int ID_W = 11;
    localparam int DW   = 32;
    localparam int NLD  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_i = 1'b0;
    logic [ID_W-1:0] id_i = '0;
    logic [DW-1:0] opa_i = '0, opb_i = '0;
    logic          cfg_wr_i = 1'b0;
    logic [ID_W-1:0] cfg_tag_i = '0;
    logic [2:0]    cfg_op_i = '0;
    logic [DW-1:0] result_o;
    logic          valid_o, miss_o, stall_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rfu_tagged_unit #(.ID_W(ID_W), .DATA_W(DW), .LOAD_CYCLES(NLD)) i_rfu_tagged_unit (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .id_i(id_i),
        .opa_i(opa_i), .opb_i(opb_i), .cfg_wr_i(cfg_wr_i),
        .cfg_tag_i(cfg_tag_i), .cfg_op_i(cfg_op_i),
        .result_o(result_o), .valid_o(valid_o), .miss_o(miss_o), .stall_o(stall_o)
    );

    // {op, tag, a, b, expected}
    localparam logic [3+ID_W+3*DW-1:0] VEC [8] = '{
        {3'd0, 11'h001, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200},
        {3'd1, 11'h7FF, 32'h0000_00F0, 32'h0000_0F0F, 32'h0000_0FFF},
        {3'd2, 11'h400, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},
        {3'd3, 11'h123, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001},
        {3'd4, 11'h0AA, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
        {3'd5, 11'h555, 32'h0000_0001, 32'h0000_0024, 32'h0000_0010},
        {3'd6, 11'h2F0, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001},
        {3'd7, 11'h00F, 32'hF000_000F, 32'h1234_5678, 32'h0000_0008}
    };

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sample_pt;
        @(negedge clk); #1;
    endtask

    // returns number of sampled cycles with stall high and issue low after strobe
    task automatic load_cfg(input logic [ID_W-1:0] t, input logic [2:0] op, output int nst);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_tag_i = t; cfg_op_i = op;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        nst = 0;
        #1;
        while (busy_seen()) begin
            nst++;
            @(negedge clk); #1;
        end
    endtask

    function automatic bit busy_seen();
        return stall_o && !issue_i;
    endfunction

    task automatic issue(input logic [ID_W-1:0] id, input logic [DW-1:0] a,
                         input logic [DW-1:0] b);
        @(negedge clk);
        issue_i = 1'b1; id_i = id; opa_i = a; opb_i = b;
        #1;
    endtask

    task automatic idle;
        @(negedge clk);
        issue_i = 1'b0; id_i = '0; opa_i = '0; opb_i = '0;
        #1;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sample_pt();
        // R7 reset state, idle
        chk(!valid_o && !miss_o && !stall_o && result_o == '0, "R7 idle after reset",
            {29'd0, valid_o, miss_o, stall_o}, '0);
        // R1 first instruction misses
        issue(11'h000, 32'h1, 32'h2);
        chk(miss_o && stall_o && !valid_o, "R1 first issue misses",
            {29'd0, valid_o, miss_o, stall_o}, 32'h3);
        idle();

        // R6/R2 vector walk
        for (int k = 0; k < 8; k++) begin
            logic [2:0] op; logic [ID_W-1:0] t; logic [DW-1:0] a, b, e;
            {op, t, a, b, e} = VEC[k];
            load_cfg(t, op, n);
            chk(n == NLD, "R4 stall length", n, NLD);
            issue(t, a, b);
            chk(valid_o && !miss_o && !stall_o, "R2 hit flags",
                {29'd0, valid_o, miss_o, stall_o}, 32'h4);
            chk(result_o == e, "R6 operation result", result_o, e);
            idle();
        end

        // R3: identifier differing only in bit 10 misses (tag is 11'h00F)
        issue(11'h40F, 32'hFFFF_FFFF, 32'h0);
        chk(miss_o && stall_o && !valid_o && result_o == '0, "R3 bit10 mismatch",
            result_o | {29'd0, valid_o, miss_o, stall_o}, 32'h3);
        // R5: stalled instruction completes after reload, with same operands held
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_tag_i = 11'h40F; cfg_op_i = 3'd3;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        n = 0;
        #1;
        while (stall_o && n < 40) begin
            if (valid_o || miss_o) chk(1'b0, "R4 quiet during load", {30'd0, valid_o, miss_o}, 0);
            n++;
            @(negedge clk); #1;
        end
        chk(n == NLD, "R4 stall length with held issue", n, NLD);
        chk(valid_o && result_o == 32'hFFFF_FFFF, "R5 held instruction completes",
            result_o, 32'hFFFF_FFFF);
        issue(11'h00F, 32'h1, 32'h1);
        chk(miss_o && !valid_o, "R5 previous tag misses", {30'd0, valid_o, miss_o}, 1);
        idle();

        // R8: second strobe during a load is ignored
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_tag_i = 11'h111; cfg_op_i = 3'd2;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        repeat (2) @(negedge clk);
        cfg_wr_i = 1'b1; cfg_tag_i = 11'h222; cfg_op_i = 3'd0;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        n = 3;
        #1;
        while (stall_o && n < 40) begin
            n++;
            @(negedge clk); #1;
        end
        chk(n == NLD, "R8 load not restarted", n, NLD);
        issue(11'h111, 32'h0000_00FF, 32'h0000_000F);
        chk(valid_o && result_o == 32'h0000_00F0, "R8 first tag kept", result_o, 32'h0000_00F0);
        issue(11'h222, 32'h1, 32'h1);
        chk(miss_o && !valid_o, "R8 ignored tag misses", {30'd0, valid_o, miss_o}, 1);
        idle();
        chk(!stall_o && !valid_o && !miss_o && result_o == '0, "R7 idle quiet",
            result_o | {29'd0, valid_o, miss_o, stall_o}, '0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule